// File: doc/BRIEF.md
# Unsigned Across-Lane Vector Reducer

This block takes one 32-bit SIMD instruction word and one 128-bit source operand. It returns a single scalar: the smallest unsigned lane of the operand, or the largest one when the max control is high. It decodes the instruction word itself. The vector-length bit picks whether 64 or 128 operand bits take part. The two-bit size field picks 8-, 16- or 32-bit lanes. The source and destination register numbers are passed through so that the surrounding register file can use them. Every fixed opcode bit is compared against the expected pattern. A word that fails any decoding rule is reported as illegal and is never written.

The reduction is a balanced comparison tree built for each lane width, followed by one register stage. An input accepted on one clock edge produces its result on the outputs during the following cycle. The scalar lands in the lowest element of a 128-bit destination value, and every bit above it is zero. The block has no condition-flag outputs.

Top module: `vred_reduce`

## Requirements
- R1: The instruction word is decoded with the vector-length bit at bit 30 (0 = 64-bit, 1 = 128-bit), the size field at bits 23:22, the source register at bits 9:5 and the destination register at bits 4:0. The two register numbers appear on `out_src_idx` and `out_dst_idx`.
- R2: All other bits must equal the fixed pattern of word 0x2E31A800, which is the encoding with every variable field zero. Any mismatch raises `out_illegal` and keeps `out_wen` low.
- R3: Size 00, 01 and 10 select 8-, 16- and 32-bit lanes. Size 11 is reserved and raises `out_illegal`.
- R4: A vector-length bit of 0 combined with size 10 raises `out_illegal`.
- R5: Lanes are compared as unsigned values. For example, between byte lanes 0x80 and 0x7F the minimum is 0x7F and the maximum is 0x80.
- R6: With `sel_max` low, the result equals a fold that starts from lane 0 and keeps the running minimum across every active lane.
- R7: With `sel_max` high, the result equals the same fold keeping the running maximum.
- R8: With the vector-length bit at 0, only operand bits 63:0 take part. Bits 127:64 have no effect on the result.
- R9: On a legal write, `out_value` holds the scalar in its lowest lane-width bits, and all higher bits are zero.
- R10: `out_valid` is high in the cycle after `in_valid` was sampled high, and low otherwise. In that cycle exactly one of `out_wen` and `out_illegal` is high. After reset, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operand are presented this cycle |
| instr | input | 32 | Instruction word |
| operand | input | 128 | Source vector |
| sel_max | input | 1 | 0 = minimum reduction, 1 = maximum reduction |
| out_valid | output | 1 | Result of the previous cycle's input is present |
| out_wen | output | 1 | Destination write enable (legal encoding) |
| out_illegal | output | 1 | Encoding rejected |
| out_src_idx | output | 5 | Decoded source register number |
| out_dst_idx | output | 5 | Decoded destination register number |
| out_value | output | 128 | Zero-extended scalar result |

## Verification
The bench aims at the comparison edge: lanes with the top bit set against lanes just below it. A design that compared signed values would return 0x80 as the minimum here. Operands for the 64-bit length carry small values in their upper half, so a design that failed to neutralise those lanes would return a wrong scalar. Flipped opcode bits, the reserved size and the forbidden 64-bit word combination are each driven on their own, to catch decoders that wrongly accept them. Random legal and illegal words, compared against a sequential fold, expose any tree that mis-pairs lanes or picks the wrong width.

// File: rtl/vred_pkg.sv
package vred_pkg;

    localparam int VEC_W     = 128;
    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 5;
    localparam int ESZ_CNT   = 3;
    localparam int LANE_MIN_W = 8;

    // Fixed opcode bits: everything except bit 30, bits 23:22 and bits 9:0
    localparam logic [INSTR_W-1:0] FIXED_MASK = 32'hBF3F_FC00;
    localparam logic [INSTR_W-1:0] FIXED_VAL  = 32'h2E31_A800;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'b00,
        ESZ_HALF = 2'b01,
        ESZ_WORD = 2'b10,
        ESZ_RSVD = 2'b11
    } esz_e;

    typedef struct packed {
        logic                 wide;
        esz_e                 esz;
        logic [REG_IDX_W-1:0] src;
        logic [REG_IDX_W-1:0] dst;
        logic                 bad;
    } dec_t;

    typedef struct packed {
        logic                 valid;
        logic                 bad;
        logic [REG_IDX_W-1:0] src;
        logic [REG_IDX_W-1:0] dst;
        logic [VEC_W-1:0]     value;
    } pipe_t;

endpackage

// File: rtl/vred_decode.sv
module vred_decode
    import vred_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);

    logic pattern_ok;
    logic size_bad;
    logic combo_bad;

    always_comb begin
        pattern_ok = ((instr_i & FIXED_MASK) == FIXED_VAL);
        dec_o.wide = instr_i[30];
        dec_o.esz  = esz_e'(instr_i[23:22]);
        dec_o.src  = instr_i[9:5];
        dec_o.dst  = instr_i[4:0];
        size_bad   = (dec_o.esz == ESZ_RSVD);
        combo_bad  = !dec_o.wide && (dec_o.esz == ESZ_WORD);
        dec_o.bad  = !pattern_ok || size_bad || combo_bad;
    end

endmodule

// File: rtl/vred_tree.sv
module vred_tree #(
    parameter int LANE_W = 8,
    parameter int LANES  = 16
) (
    input  logic [LANE_W*LANES-1:0] vec_i,
    input  logic                    pick_max_i,
    output logic [LANE_W-1:0]       res_o
);

    localparam int NODES = 2 * LANES - 1;

    // Heap layout: node 0 is the root, leaves sit at LANES-1 .. NODES-1
    logic [LANE_W-1:0] node [NODES];

    genvar l, n;
    generate
        for (l = 0; l < LANES; l++) begin : g_leaf
            assign node[LANES-1+l] = vec_i[l*LANE_W +: LANE_W];
        end
        for (n = 0; n < LANES - 1; n++) begin : g_cmp
            logic a_lt_b;
            assign a_lt_b  = node[2*n+1] < node[2*n+2];
            assign node[n] = (a_lt_b ^ pick_max_i) ? node[2*n+1] : node[2*n+2];
        end
    endgenerate

    assign res_o = node[0];

endmodule

// File: rtl/vred_reduce.sv
module vred_reduce
    import vred_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [31:0]          instr,
    input  logic [127:0]         operand,
    input  logic                 sel_max,
    output logic                 out_valid,
    output logic                 out_wen,
    output logic                 out_illegal,
    output logic [4:0]           out_src_idx,
    output logic [4:0]           out_dst_idx,
    output logic [127:0]         out_value
);

    localparam int HALF_W = VEC_W / 2;

    dec_t             dec;
    logic [VEC_W-1:0] op_masked;
    logic [VEC_W-1:0] ext_res [ESZ_CNT];
    pipe_t            pipe_d, pipe_q;

    vred_decode u_dec (
        .instr_i (instr),
        .dec_o   (dec)
    );

    // Short vectors: upper half replaced by the neutral value of the fold
    always_comb begin
        op_masked = operand;
        if (!dec.wide) begin
            op_masked[VEC_W-1:HALF_W] = sel_max ? '0 : '1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < ESZ_CNT; g++) begin : g_width
            localparam int EW    = LANE_MIN_W << g;
            localparam int LANES = VEC_W / EW;
            logic [EW-1:0] res;
            vred_tree #(.LANE_W(EW), .LANES(LANES)) u_tree (
                .vec_i      (op_masked),
                .pick_max_i (sel_max),
                .res_o      (res)
            );
            assign ext_res[g] = {{(VEC_W-EW){1'b0}}, res};
        end
    endgenerate

    always_comb begin
        pipe_d.valid = in_valid;
        pipe_d.bad   = dec.bad;
        pipe_d.src   = dec.src;
        pipe_d.dst   = dec.dst;
        unique case (dec.esz)
            ESZ_BYTE: pipe_d.value = ext_res[0];
            ESZ_HALF: pipe_d.value = ext_res[1];
            ESZ_WORD: pipe_d.value = ext_res[2];
            default:  pipe_d.value = '0;
        endcase
        if (dec.bad) begin
            pipe_d.value = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid   = pipe_q.valid;
    assign out_wen     = pipe_q.valid && !pipe_q.bad;
    assign out_illegal = pipe_q.valid && pipe_q.bad;
    assign out_src_idx = pipe_q.src;
    assign out_dst_idx = pipe_q.dst;
    assign out_value   = pipe_q.value;

endmodule

// File: rtl/vred_checker.sv
module vred_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [31:0]  instr,
    input logic [127:0] operand,
    input logic         sel_max,
    input logic         out_valid,
    input logic         out_wen,
    input logic         out_illegal,
    input logic [4:0]   out_src_idx,
    input logic [4:0]   out_dst_idx,
    input logic [127:0] out_value
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid lost"); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("spurious valid"); // R10

    AST_WEN_XOR_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wen != out_illegal)) else $error("wen/illegal clash"); // R10

    AST_DST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dst_idx == $past(instr[4:0]))) else $error("dst index"); // R1

    AST_RSVD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[23:22] == 2'b11) |=> out_illegal) else $error("size 11 accepted"); // R3

    AST_SHORT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[30] && instr[23:22] == 2'b10) |=> out_illegal) else $error("short word accepted"); // R4

    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[23:22] == 2'b00) |=> (!out_wen || out_value[127:8] == '0)) else $error("upper bits set"); // R9

    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sel_max && instr[23:22] == 2'b00)
        |=> (!out_wen || out_value[7:0] <= $past(operand[7:0]))) else $error("min above lane 0"); // R6

    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_max && instr[23:22] == 2'b00)
        |=> (!out_wen || out_value[7:0] >= $past(operand[7:0]))) else $error("max below lane 0"); // R7

endmodule

bind vred_reduce vred_checker u_chk (.*);

// File: tb/tb_vred_reduce.sv
`timescale 1ns/1ps
module tb_vred_reduce;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] operand = '0;
    logic         sel_max = 1'b0;
    logic         out_valid, out_wen, out_illegal;
    logic [4:0]   out_src_idx, out_dst_idx;
    logic [127:0] out_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vred_reduce dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .operand(operand), .sel_max(sel_max), .out_valid(out_valid),
        .out_wen(out_wen), .out_illegal(out_illegal), .out_src_idx(out_src_idx),
        .out_dst_idx(out_dst_idx), .out_value(out_value)
    );

    function automatic logic [31:0] mk(logic q, logic [1:0] sz, logic [4:0] rn, logic [4:0] rd);
        return 32'h2E31A800 | (32'(q) << 30) | (32'(sz) << 22) | (32'(rn) << 5) | 32'(rd);
    endfunction

    function automatic bit exp_bad(logic [31:0] w);
        bit pat_bad = (w & 32'hBF3FFC00) != 32'h2E31A800;
        return pat_bad || (w[23:22] == 2'b11) || (!w[30] && w[23:22] == 2'b10);
    endfunction

    // Sequential fold from lane 0
    function automatic logic [127:0] exp_val(logic q, logic [1:0] sz, logic [127:0] op, logic mx);
        int ew = 8 << sz;
        int n = (q ? 128 : 64) / ew;
        logic [31:0] msk = (ew == 32) ? 32'hFFFF_FFFF : ((32'd1 << ew) - 1);
        logic [31:0] acc = op[31:0] & msk;
        for (int i = 1; i < n; i++) begin
            logic [31:0] e = 32'(op >> (i * ew)) & msk;
            if (mx ? (e > acc) : (e < acc)) acc = e;
        end
        return {96'd0, acc};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [31:0] w, logic [127:0] op, logic mx);
        bit bad = exp_bad(w);
        @(negedge clk);
        in_valid = 1'b1; instr = w; operand = op; sel_max = mx;
        @(negedge clk);
        chk({req, " R10 valid"}, 128'(out_valid), 128'd1);
        chk({req, " R2 illegal"}, 128'(out_illegal), 128'(bad));
        chk({req, " R10 wen"}, 128'(out_wen), 128'(!bad));
        chk({req, " R1 dst"}, 128'(out_dst_idx), 128'(w[4:0]));
        chk({req, " R1 src"}, 128'(out_src_idx), 128'(w[9:5]));
        if (!bad) chk({req, " R9 value"}, out_value, exp_val(w[30], w[23:22], op, mx));
        in_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R10 reset valid", 128'(out_valid), 128'd0);
        chk("R10 reset wen", 128'(out_wen), 128'd0);
        chk("R10 reset illegal", 128'(out_illegal), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run("R2 base word", 32'h2E31A800, 128'h0123_4567_89AB_CDEF_1122_3344_5566_7788, 1'b0);
        run("R5 unsigned min", mk(1'b0, 2'b00, 5'd3, 5'd7), {64'h0, 64'h8080_8080_8080_807F}, 1'b0);
        run("R5 unsigned max", mk(1'b0, 2'b00, 5'd3, 5'd7), {64'h0, 64'h7F7F_7F7F_7F7F_7F80}, 1'b1);
        run("R8 upper ignored min", mk(1'b0, 2'b01, 5'd1, 5'd2), {64'h0001_0001_0001_0001, 64'hFFFF_FFF0_FFFF_FFFF}, 1'b0);
        run("R8 upper ignored max", mk(1'b0, 2'b00, 5'd1, 5'd2), {64'hFFFF_FFFF_FFFF_FFFF, 64'h0102_0304_0506_0708}, 1'b1);
        run("R6 word min", mk(1'b1, 2'b10, 5'd31, 5'd31), 128'h8000_0000_0000_0005_7FFF_FFFF_0000_0009, 1'b0);
        run("R7 word max", mk(1'b1, 2'b10, 5'd4, 5'd5), 128'h8000_0000_0000_0005_7FFF_FFFF_0000_0009, 1'b1);
        run("R6 byte last lane", mk(1'b1, 2'b00, 5'd9, 5'd10), 128'h01FF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b0);
        run("R3 reserved size", mk(1'b1, 2'b11, 5'd0, 5'd1), '1, 1'b0);
        run("R4 short word", mk(1'b0, 2'b10, 5'd2, 5'd3), '1, 1'b0);
        run("R2 bit31 flip", mk(1'b1, 2'b00, 5'd0, 5'd0) | 32'h8000_0000, '1, 1'b0);
        run("R2 bit16 flip", mk(1'b1, 2'b00, 5'd0, 5'd0) & ~32'h0001_0000, '1, 1'b0);
        run("R2 bit12 flip", mk(1'b1, 2'b01, 5'd0, 5'd0) ^ 32'h0000_1000, '1, 1'b0);

        @(negedge clk);
        chk("R10 idle", 128'(out_valid), 128'd0);

        for (int k = 0; k < 400; k++) begin
            logic [31:0] w = mk(1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom));
            logic [127:0] op = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 9) == 0) w ^= (32'd1 << $urandom_range(10, 21));
            if ($urandom_range(0, 3) == 0) op &= {4{32'h8181_8181}};
            run("R6 R7 random", w, op, 1'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule